// File: doc/BRIEF.md
# DMA Request Sensing Controller

This block decides, one byte at a time, whether a single memory-to-I/O DMA channel holds the bus or hands it back to the CPU. It watches an active-low request pin, which can be set to level or edge sensitivity. While it owns the bus it steps through the T-states of each byte transfer: a read machine cycle, then a write machine cycle that carries a configurable number of wait states. Data movement and address generation sit in neighbouring logic, which follows the T-state and phase outputs. Those neighbours also own any arbitration between channels.

Software loads a 16-bit byte count and then pulses the arm input. The request pin passes through a synchronizer. It is sampled once per byte, on the clock edge that ends the state just before the write T3. That sample decides whether the next byte follows at once or the CPU gets the bus back. The transfer-end output is high for the whole byte that runs while the count reads zero. After that byte the channel disarms itself.

Top module: `dma_req_sense`

## Requirements
- R1: After reset the CPU owns the bus (`dma_owner`=0), `tstate` is 0 (idle), `xfer_last` is 0, `byte_count` is 0 and the channel is disarmed.
- R2: The channel starts only after a pulse on `arm_start`. A request seen while the channel is disarmed has no effect on `dma_owner`.
- R3: Level mode (`edge_mode`=0): an armed idle channel takes the bus while the synchronized `dreq_n` is low. If `dreq_n` is high at the sample point, the current byte completes and the bus goes back to the CPU. It is taken again when `dreq_n` next reads low.
- R4: `dreq_n` passes through a two-flop synchronizer. The sample point is the clock edge that ends write T2 when zero waits are set, and otherwise the edge that ends the last Tw.
- R5: Edge mode (`edge_mode`=1): an armed idle channel takes the bus only after a falling edge of `dreq_n`. A pulse on `arm_start` clears any edge recorded earlier.
- R6: Edge mode: the next byte follows without a break only if a new falling edge arrived after the previous grant and by the sample point. Otherwise the bus is released after the current byte.
- R7: Edge mode: once the CPU has the bus, a steady low `dreq_n` does not take it back. Only a new falling edge does.
- R8: Each byte is the sequence read T1, T2, T3, then write T1, T2, N×Tw, T3, with N = `wait_cfg` (0..3, recommended setting 2). `tstate` codes are: 0 idle, 1 T1, 2 T2, 3 Tw, 4 T3. `write_phase` is 1 during the write cycle.
- R9: `cnt_load` writes `cnt_value` into the byte count. The count decrements by one on the clock edge that ends every write T3.
- R10: `xfer_last` is high for every T-state of the byte that runs while the count is 0. After that byte the channel disarms and releases the bus whatever `dreq_n` does, and the count wraps to FFFFh.
- R11: `dma_owner` rises only into a read T1 and falls only after a write T3, so no machine cycle is ever cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| edge_mode | input | 1 | 0 = level-sensitive request, 1 = edge-sensitive |
| arm_start | input | 1 | One-cycle pulse that enables the channel |
| cnt_load | input | 1 | Loads `cnt_value` into the byte count |
| cnt_value | input | 16 | Byte count value to load |
| dreq_n | input | 1 | Active-low DMA request (asynchronous) |
| wait_cfg | input | 2 | Number of Tw states in the write cycle |
| dma_owner | output | 1 | 1 while the DMA channel owns the bus |
| tstate | output | 3 | Current T-state code (0 idle, 1 T1, 2 T2, 3 Tw, 4 T3) |
| write_phase | output | 1 | 1 during the write machine cycle |
| xfer_last | output | 1 | High throughout the final byte transfer |
| byte_count | output | 16 | Remaining byte count |

## Verification
If the recorded edge flag is not cleared correctly, edge-mode runs come out one byte too long or too short. This appears at `dma_owner` within one byte time, about ten cycles. A sample point in the wrong place shows up as a level-mode release that comes one byte late after `dreq_n` goes high. A wrong wait-state counter stretches or shortens the `tstate` trace within the first write cycle. An off-by-one in the count appears as the wrong number of T3 write states before `xfer_last`, and as a `byte_count` other than FFFFh at release.

// File: rtl/dma_sense_pkg.sv
package dma_sense_pkg;
  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_TW   = 3'd3,
    TS_T3   = 3'd4
  } tstate_e;
endpackage

// File: rtl/dma_req_sync.sv
// Synchronizes the request pin and keeps a sticky flag for falling edges.
module dma_req_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n_async,
  input  logic flag_clr,
  output logic req_low,
  output logic fall_now,
  output logic fall_flag
);
  localparam int LAST = SYNC_STAGES;

  logic [LAST:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b1;
    else        chain[0] <= req_n_async;
  end

  for (genvar i = 1; i <= LAST; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b1;
      else        chain[i] <= chain[i-1];
    end
  end

  assign req_low  = ~chain[LAST-1];
  assign fall_now = chain[LAST] & ~chain[LAST-1];

  // An edge that is consumed in the same cycle it appears is not kept.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fall_flag <= 1'b0;
    else        fall_flag <= (fall_flag | fall_now) & ~flag_clr;
  end
endmodule

// File: rtl/dma_tseq.sv
// Steps through the T-states of one byte: a read cycle, then a write cycle.
module dma_tseq
  import dma_sense_pkg::*;
#(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              run_next,
  input  logic [WAIT_W-1:0] wait_cfg,
  output tstate_e           state,
  output logic              wr,
  output logic              sample_pt,
  output logic              done
);
  logic [WAIT_W-1:0] wq;
  logic [WAIT_W-1:0] wleft;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= TS_IDLE;
      wr    <= 1'b0;
      wq    <= '0;
      wleft <= '0;
    end else begin
      unique case (state)
        TS_IDLE: if (start) begin
          state <= TS_T1;
          wr    <= 1'b0;
        end
        TS_T1: state <= TS_T2;
        TS_T2: if (wr && wq != '0) begin
          state <= TS_TW;
          wleft <= wq - 1'b1;
        end else begin
          state <= TS_T3;
        end
        TS_TW: if (wleft == '0) state <= TS_T3;
               else             wleft <= wleft - 1'b1;
        TS_T3: if (!wr) begin
          state <= TS_T1;
          wr    <= 1'b1;
          wq    <= wait_cfg;
        end else if (run_next) begin
          state <= TS_T1;
          wr    <= 1'b0;
        end else begin
          state <= TS_IDLE;
          wr    <= 1'b0;
        end
        default: state <= TS_IDLE;
      endcase
    end
  end

  assign sample_pt = wr && ((state == TS_T2 && wq == '0) ||
                            (state == TS_TW && wleft == '0));
  assign done      = wr && state == TS_T3;
endmodule

// File: rtl/dma_byte_counter.sv
module dma_byte_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] count,
  output logic             is_zero
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (load) count <= load_val;
    else if (dec)  count <= count - 1'b1;
  end

  assign is_zero = (count == '0);
endmodule

// File: rtl/dma_req_sense.sv
module dma_req_sense
  import dma_sense_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int WAIT_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              edge_mode,
  input  logic              arm_start,
  input  logic              cnt_load,
  input  logic [CNT_W-1:0]  cnt_value,
  input  logic              dreq_n,
  input  logic [WAIT_W-1:0] wait_cfg,
  output logic              dma_owner,
  output logic [2:0]        tstate,
  output logic              write_phase,
  output logic              xfer_last,
  output logic [CNT_W-1:0]  byte_count
);
  logic    req_low, fall_now, fall_flag, flag_clr;
  logic    armed, keep_q, go, run_next, edge_take;
  logic    sample_pt, done, cnt_zero;
  tstate_e st;

  dma_req_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_n_async(dreq_n),
    .flag_clr   (flag_clr),
    .req_low    (req_low),
    .fall_now   (fall_now),
    .fall_flag  (fall_flag)
  );

  dma_tseq #(.WAIT_W(WAIT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (go),
    .run_next (run_next),
    .wait_cfg (wait_cfg),
    .state    (st),
    .wr       (write_phase),
    .sample_pt(sample_pt),
    .done     (done)
  );

  dma_byte_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cnt_load),
    .load_val(cnt_value),
    .dec     (done),
    .count   (byte_count),
    .is_zero (cnt_zero)
  );

  assign edge_take = fall_flag | fall_now;
  assign go        = armed && (st == TS_IDLE) && (edge_mode ? edge_take : req_low);
  assign flag_clr  = arm_start | sample_pt | (go & edge_mode);
  assign run_next  = keep_q && !cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                armed <= 1'b0;
    else if (arm_start)        armed <= 1'b1;
    else if (done && cnt_zero) armed <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         keep_q <= 1'b0;
    else if (sample_pt) keep_q <= edge_mode ? edge_take : req_low;
  end

  assign tstate    = st;
  assign dma_owner = (st != TS_IDLE);
  assign xfer_last = dma_owner && cnt_zero;
endmodule

// File: rtl/dma_req_sense_chk.sv
module dma_req_sense_chk
  import dma_sense_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_load,
  input logic             dma_owner,
  input logic [2:0]       tstate,
  input logic             write_phase,
  input logic             xfer_last,
  input logic [CNT_W-1:0] byte_count
);
  AST_GRANT_AT_READ_T1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_owner) |-> (tstate == TS_T1 && !write_phase)); // R11
  AST_RELEASE_AFTER_WRITE_T3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_owner) |-> ($past(tstate) == TS_T3 && $past(write_phase))); // R11
  AST_T1_THEN_T2: assert property (@(posedge clk) disable iff (!rst_n)
    (tstate == TS_T1) |=> (tstate == TS_T2)); // R8
  AST_COUNT_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (tstate == TS_T3 && write_phase && !cnt_load) |=>
      (byte_count == $past(byte_count) - 1'b1)); // R9
  AST_LAST_MEANS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_last |-> (dma_owner && byte_count == '0)); // R10
  AST_FINAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (tstate == TS_T3 && write_phase && byte_count == '0 && !cnt_load) |=> !dma_owner); // R10
endmodule

bind dma_req_sense dma_req_sense_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnt_load   (cnt_load),
  .dma_owner  (dma_owner),
  .tstate     (tstate),
  .write_phase(write_phase),
  .xfer_last  (xfer_last),
  .byte_count (byte_count)
);

// File: tb/test_dma_req_sense.sv
module test_dma_req_sense;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, edge_mode, arm_start, cnt_load, dreq_n, dma_owner, write_phase, xfer_last;
  logic [15:0] cnt_value, byte_count;
  logic [1:0]  wait_cfg;
  logic [2:0]  tstate;

  int n_tests = 0, n_fail = 0, n_xfer, n_last;
  logic [3:0] seq_rec [0:11];
  bit ok;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_req_sense i_dma_req_sense (
    .clk(clk), .rst_n(rst_n), .edge_mode(edge_mode), .arm_start(arm_start),
    .cnt_load(cnt_load), .cnt_value(cnt_value), .dreq_n(dreq_n), .wait_cfg(wait_cfg),
    .dma_owner(dma_owner), .tstate(tstate), .write_phase(write_phase),
    .xfer_last(xfer_last), .byte_count(byte_count)
  );

  task automatic chk(input bit cond, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic em, input logic [1:0] wc);
    @(negedge clk);
    rst_n = 1'b0; edge_mode = em; wait_cfg = wc; arm_start = 1'b0;
    cnt_load = 1'b0; cnt_value = '0; dreq_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load_arm(input logic [15:0] v);
    cnt_load = 1'b1; cnt_value = v; arm_start = 1'b1;
    @(negedge clk);
    cnt_load = 1'b0; arm_start = 1'b0;
  endtask

  task automatic wait_grant(output bit got);
    got = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (dma_owner) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  // From a cycle with dma_owner high, runs until the bus is released.
  task automatic capture();
    int idx = 0;
    n_xfer = 0; n_last = 0;
    for (int k = 0; k < 400 && dma_owner; k++) begin
      if (idx < 12) seq_rec[idx] = {write_phase, tstate};
      idx++;
      if (tstate == 3'd4 && write_phase) n_xfer++;
      if (xfer_last) n_last++;
      @(negedge clk);
    end
  endtask

  task automatic hold_idle(input int cycles, input string req, input string what);
    int seen = 0;
    for (int k = 0; k < cycles; k++) begin
      if (dma_owner) seen++;
      @(negedge clk);
    end
    chk(seen == 0, req, what, seen, 0);
  endtask

  task automatic t_reset();
    do_reset(1'b0, 2'd2);
    chk(dma_owner == 1'b0, "R1", "owner after reset", dma_owner, 0);
    chk(tstate == 3'd0, "R1", "tstate after reset", tstate, 0);
    chk(xfer_last == 1'b0, "R1", "xfer_last after reset", xfer_last, 0);
    chk(byte_count == 16'd0, "R1", "count after reset", byte_count, 0);
  endtask

  task automatic t_unarmed();
    do_reset(1'b0, 2'd2);
    dreq_n = 1'b0;
    hold_idle(12, "R2", "grant while disarmed");
  endtask

  task automatic t_level_run();
    logic [3:0] exp_seq [0:7] = '{4'd1, 4'd2, 4'd4, 4'd9, 4'd10, 4'd11, 4'd11, 4'd12};
    int bad = 0;
    do_reset(1'b0, 2'd2);
    dreq_n = 1'b0;
    load_arm(16'd3);
    wait_grant(ok);
    chk(ok, "R3", "level grant with dreq low", ok, 1);
    capture();
    for (int i = 0; i < 8; i++) if (seq_rec[i] != exp_seq[i]) bad++;
    chk(bad == 0, "R8", "tstate trace with two waits (mismatches)", bad, 0);
    chk(n_xfer == 4, "R9", "bytes in one ownership for count 3", n_xfer, 4);
    chk(n_last == 8, "R10", "xfer_last cycles", n_last, 8);
    chk(byte_count == 16'hFFFF, "R10", "count after final byte", byte_count, 16'hFFFF);
    hold_idle(10, "R10", "grant after channel disarmed");
  endtask

  task automatic t_level_yield();
    do_reset(1'b0, 2'd2);
    dreq_n = 1'b0;
    load_arm(16'd5);
    wait_grant(ok);
    dreq_n = 1'b1;
    capture();
    chk(n_xfer == 1, "R3", "bytes after dreq high", n_xfer, 1);
    chk(byte_count == 16'd4, "R9", "count after one byte", byte_count, 4);
    hold_idle(10, "R3", "grant while dreq high");
    dreq_n = 1'b0;
    wait_grant(ok);
    chk(ok, "R3", "regrant on dreq low", ok, 1);
    dreq_n = 1'b1;
    capture();
    chk(n_xfer == 1 && byte_count == 16'd3, "R4", "second yield byte/count", byte_count, 3);
  endtask

  task automatic t_edge_single();
    do_reset(1'b1, 2'd2);
    load_arm(16'd5);
    hold_idle(5, "R5", "grant without falling edge");
    dreq_n = 1'b0;
    wait_grant(ok);
    chk(ok, "R5", "edge grant", ok, 1);
    capture();
    chk(n_xfer == 1, "R6", "bytes without new edge", n_xfer, 1);
    hold_idle(20, "R7", "grant on steady low");
    dreq_n = 1'b1;
    repeat (4) @(negedge clk);
    dreq_n = 1'b0;
    wait_grant(ok);
    chk(ok, "R7", "regrant on new edge", ok, 1);
    capture();
    chk(n_xfer == 1 && byte_count == 16'd3, "R6", "count after two single bytes", byte_count, 3);
  endtask

  task automatic t_edge_continue();
    do_reset(1'b1, 2'd3);
    load_arm(16'd5);
    dreq_n = 1'b0;
    wait_grant(ok);
    dreq_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    dreq_n = 1'b0;
    capture();
    chk(n_xfer == 2, "R6", "bytes with edge before sample point", n_xfer, 2);
    chk(byte_count == 16'd3, "R9", "count after two bytes", byte_count, 3);
  endtask

  task automatic t_waits(input logic [1:0] wc, input int exp_len);
    int len = 0;
    do_reset(1'b0, wc);
    dreq_n = 1'b0;
    load_arm(16'd0);
    wait_grant(ok);
    while (dma_owner && len < 50) begin len++; @(negedge clk); end
    chk(len == exp_len, "R8", "byte length in cycles", len, exp_len);
    chk(byte_count == 16'hFFFF, "R10", "single-byte wrap", byte_count, 16'hFFFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_unarmed();
    t_level_run();
    t_level_yield();
    t_edge_single();
    t_edge_continue();
    t_waits(2'd0, 6);
    t_waits(2'd1, 7);
    t_waits(2'd3, 9);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule